// File: doc/BRIEF.md
# Guest Trap and Exit Filter

This block sits beside a processor core that runs guest software on behalf of a hypervisor. Each cycle it looks at the events the guest produces: exception reports with a vector, error code and fault address, guest writes to control register CR0, and the guest's interrupt-enable flag. For each event it decides whether the guest may carry on or must hand control back to the hypervisor. When control must go back, it raises a one-cycle exit strobe and holds a reason code and the event details until the hypervisor signals the next entry.

The hypervisor sets the policy ahead of time through a small write-only register port. The settings are a per-vector exception trap bitmap, a mask/match pair that narrows page-fault trapping by error code, a CR0 ownership mask with a read shadow, and an interrupt-window enable. The block keeps the real guest CR0. It returns a blended CR0 value for guest reads, applies guest CR0 writes that do not need to trap, and holds one pending injected event. That event is presented to the core on the next entry.

Top module: `guest_exit_filter`

## Requirements
- R1: In guest mode, an exception whose vector v is not 14 causes an exit exactly when bit v of the trap bitmap (config address 0) is 1, and this includes vector 7. Otherwise the exception is passed to the guest, and `excDeliver` pulses for one cycle.
- R2: A page fault (vector 14) causes an exit when the test `(errCode & pfMask) == pfMatch` gives the same result as bitmap bit 14, and is passed to the guest otherwise. pfMask is at config address 3 and pfMatch at address 4.
- R3: In guest mode, a CR0 write causes an exit when any bit set in the ownership mask (address 1) differs between the written value and the read shadow (address 2). No bit of such a write reaches the guest CR0.
- R4: A CR0 write that does not exit copies the written value into the unmasked bits of the guest CR0 and leaves the masked bits unchanged. The hypervisor can load the guest CR0 directly at address 6.
- R5: `crRdData` equals the read shadow in every masked bit position and the guest CR0 in every unmasked bit position.
- R6: When bit 0 of address 5 (interrupt-window enable) is 1, the first guest-mode cycle with `guestIf` = 1 causes an exit.
- R7: An exit latches a reason code: 1 for exception, 2 for CR0 write, 3 for interrupt window. An exception exit also latches the vector and error code, with the fault address in `exitInfo`. A CR0 exit puts the written value in `exitInfo`. A window exit puts zero in both.
- R8: When several exit causes occur in the same cycle, the exception is reported first, then the CR0 write, then the interrupt window. While any exit is taken, no CR0 write is applied.
- R9: `exitStrobe` is high for exactly one cycle per exit. The exit takes the block out of guest mode, and events that arrive outside guest mode cause no exit, no delivery and no CR0 update.
- R10: The latched exit details stay stable until `vmEnter`, which sets guest mode and clears them to zero.
- R11: A write to address 7 makes an event pending, with the vector in bits 4:0 and the has-error-code flag in bit 8. The error code is written at address 8. The next `vmEnter` pulses `injStrobe` for one cycle, presents the event, clears the pending state and causes no exit, whatever the bitmap says.
- R12: After reset all policy registers and the guest CR0 are zero, the block is out of guest mode, and every output strobe and latched detail is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Policy register write strobe |
| cfgAddr | input | 4 | Policy register address |
| cfgWrData | input | 32 | Policy register write data |
| vmEnter | input | 1 | Hypervisor enters the guest |
| excValid | input | 1 | Guest exception report valid |
| excVector | input | 5 | Exception vector |
| excErrCode | input | 32 | Exception error code |
| excAddr | input | 32 | Fault-specific data (faulting address) |
| crWrValid | input | 1 | Guest CR0 write valid |
| crWrData | input | 32 | Guest CR0 write value |
| guestIf | input | 1 | Guest interrupt-enable flag |
| crRdData | output | 32 | Virtualised CR0 value for guest reads |
| guestCr0 | output | 32 | Real guest CR0 |
| inGuest | output | 1 | Guest mode active |
| exitStrobe | output | 1 | One-cycle exit pulse |
| exitReason | output | 2 | Latched exit reason code |
| exitVector | output | 5 | Latched exception vector |
| exitErrCode | output | 32 | Latched exception error code |
| exitInfo | output | 32 | Latched fault address or CR0 write value |
| excDeliver | output | 1 | Exception passed directly to the guest |
| injStrobe | output | 1 | Injected event presented on entry |
| injVector | output | 5 | Injected event vector |
| injHasErr | output | 1 | Injected event carries an error code |
| injErrCode | output | 32 | Injected event error code |

## Verification
The exception filter is driven from a table that pairs one bitmap bit with a matching vector and with a neighbouring vector. This separates per-vector selection from a decode that ignores the bitmap. The page-fault rows cover all four combinations of the mask/match result against bit 14, which exposes an inverted or missing agreement test. The CR0 path is tried with a write that agrees with the shadow and one that differs in an owned bit, and the checks look at both the blended read value and the real register. Cycles with several causes at once, events outside guest mode, a closed and then open interrupt window, and an injection with its trap bit set check priority, gating and the no-exit rule for injection.

// File: rtl/gef_pkg.sv
package gef_pkg;
  typedef enum logic [1:0] {
    RSN_NONE = 2'd0,
    RSN_EXC  = 2'd1,
    RSN_CR0  = 2'd2,
    RSN_WIN  = 2'd3
  } exitReason_t;

  typedef struct packed {
    logic enter;
    logic exitExc;
    logic exitCr;
    logic exitWin;
    logic crCommit;
    logic excPass;
  } ctrlStrobes_t;

  localparam logic [3:0] A_BITMAP  = 4'd0;
  localparam logic [3:0] A_CRMASK  = 4'd1;
  localparam logic [3:0] A_SHADOW  = 4'd2;
  localparam logic [3:0] A_PFMASK  = 4'd3;
  localparam logic [3:0] A_PFMATCH = 4'd4;
  localparam logic [3:0] A_CTRL    = 4'd5;
  localparam logic [3:0] A_GCR0    = 4'd6;
  localparam logic [3:0] A_INJ     = 4'd7;
  localparam logic [3:0] A_INJERR  = 4'd8;
endpackage

// File: rtl/gef_ctrl.sv
module gef_ctrl
  import gef_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 5,
  parameter int PF_VECTOR = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  vmEnter,
  input  logic                  excValid,
  input  logic [VEC_W-1:0]      excVector,
  input  logic [DATA_W-1:0]     excErrCode,
  input  logic                  crWrValid,
  input  logic [DATA_W-1:0]     crWrData,
  input  logic                  guestIf,
  input  logic [(1<<VEC_W)-1:0] excBitmap,
  input  logic [DATA_W-1:0]     cr0Mask,
  input  logic [DATA_W-1:0]     cr0Shadow,
  input  logic [DATA_W-1:0]     pfMask,
  input  logic [DATA_W-1:0]     pfMatch,
  input  logic                  winEn,
  output logic                  inGuest,
  output ctrlStrobes_t          strb
);
  localparam logic [VEC_W-1:0] PF_VEC = VEC_W'(PF_VECTOR);

  logic pfHit, excWants, crWants, anyExit;

  always_comb begin
    pfHit    = ((excErrCode & pfMask) == pfMatch);
    excWants = (excVector == PF_VEC) ? (pfHit == excBitmap[PF_VECTOR])
                                     : excBitmap[excVector];
    crWants  = |((crWrData ^ cr0Shadow) & cr0Mask);

    strb          = '0;
    strb.enter    = vmEnter;
    strb.exitExc  = inGuest && excValid && excWants;
    strb.exitCr   = inGuest && crWrValid && crWants && !strb.exitExc;
    strb.exitWin  = inGuest && winEn && guestIf && !strb.exitExc && !strb.exitCr;
    anyExit       = strb.exitExc || strb.exitCr || strb.exitWin;
    strb.crCommit = inGuest && crWrValid && !crWants && !anyExit;
    strb.excPass  = inGuest && excValid && !excWants;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        inGuest <= 1'b0;
    else if (vmEnter) inGuest <= 1'b1;
    else if (anyExit) inGuest <= 1'b0;
  end
endmodule

// File: rtl/gef_dpath.sv
module gef_dpath
  import gef_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 5,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [DATA_W-1:0]     cfgWrData,
  input  ctrlStrobes_t          strb,
  input  logic                  inGuest,
  input  logic [VEC_W-1:0]      excVector,
  input  logic [DATA_W-1:0]     excErrCode,
  input  logic [DATA_W-1:0]     excAddr,
  input  logic [DATA_W-1:0]     crWrData,
  output logic [(1<<VEC_W)-1:0] excBitmap,
  output logic [DATA_W-1:0]     cr0Mask,
  output logic [DATA_W-1:0]     cr0Shadow,
  output logic [DATA_W-1:0]     pfMask,
  output logic [DATA_W-1:0]     pfMatch,
  output logic                  winEn,
  output logic [DATA_W-1:0]     crRdData,
  output logic [DATA_W-1:0]     guestCr0,
  output logic                  exitStrobe,
  output logic [1:0]            exitReason,
  output logic [VEC_W-1:0]      exitVector,
  output logic [DATA_W-1:0]     exitErrCode,
  output logic [DATA_W-1:0]     exitInfo,
  output logic                  excDeliver,
  output logic                  injStrobe,
  output logic [VEC_W-1:0]      injVector,
  output logic                  injHasErr,
  output logic [DATA_W-1:0]     injErrCode
);
  localparam int BM_W    = 1 << VEC_W;
  localparam int ERR_BIT = 8;

  logic                injPending;
  logic [VEC_W-1:0]    pendVector;
  logic                pendHasErr;
  logic [DATA_W-1:0]   pendErr;
  logic                anyExit, gcrCfgWr;
  exitReason_t         nextReason;

  assign anyExit  = strb.exitExc || strb.exitCr || strb.exitWin;
  assign gcrCfgWr = cfgWrEn && (cfgAddr == ADDR_W'(A_GCR0));
  assign crRdData = (cr0Shadow & cr0Mask) | (guestCr0 & ~cr0Mask);

  always_comb begin
    if (strb.exitExc)     nextReason = RSN_EXC;
    else if (strb.exitCr) nextReason = RSN_CR0;
    else                  nextReason = RSN_WIN;
  end

  // policy registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      excBitmap <= '0;
      cr0Mask   <= '0;
      cr0Shadow <= '0;
      pfMask    <= '0;
      pfMatch   <= '0;
      winEn     <= 1'b0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        ADDR_W'(A_BITMAP):  excBitmap <= cfgWrData[BM_W-1:0];
        ADDR_W'(A_CRMASK):  cr0Mask   <= cfgWrData;
        ADDR_W'(A_SHADOW):  cr0Shadow <= cfgWrData;
        ADDR_W'(A_PFMASK):  pfMask    <= cfgWrData;
        ADDR_W'(A_PFMATCH): pfMatch   <= cfgWrData;
        ADDR_W'(A_CTRL):    winEn     <= cfgWrData[0];
        default: ;
      endcase
    end
  end

  // real guest CR0
  always_ff @(posedge clk) begin
    if (!rstN)              guestCr0 <= '0;
    else if (gcrCfgWr)      guestCr0 <= cfgWrData;
    else if (strb.crCommit) guestCr0 <= (guestCr0 & cr0Mask) | (crWrData & ~cr0Mask);
  end

  // exit strobe and latched details
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exitStrobe  <= 1'b0;
      exitReason  <= RSN_NONE;
      exitVector  <= '0;
      exitErrCode <= '0;
      exitInfo    <= '0;
      excDeliver  <= 1'b0;
    end else begin
      exitStrobe <= anyExit && !strb.enter;
      excDeliver <= strb.excPass;
      if (strb.enter) begin
        exitReason  <= RSN_NONE;
        exitVector  <= '0;
        exitErrCode <= '0;
        exitInfo    <= '0;
      end else if (anyExit) begin
        exitReason  <= nextReason;
        exitVector  <= strb.exitExc ? excVector : '0;
        exitErrCode <= strb.exitExc ? excErrCode : '0;
        exitInfo    <= strb.exitExc ? excAddr : (strb.exitCr ? crWrData : '0);
      end
    end
  end

  // pending injected event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      injPending <= 1'b0;
      pendVector <= '0;
      pendHasErr <= 1'b0;
      pendErr    <= '0;
      injStrobe  <= 1'b0;
      injVector  <= '0;
      injHasErr  <= 1'b0;
      injErrCode <= '0;
    end else begin
      injStrobe <= strb.enter && injPending;
      if (strb.enter) begin
        injPending <= 1'b0;
        if (injPending) begin
          injVector  <= pendVector;
          injHasErr  <= pendHasErr;
          injErrCode <= pendErr;
        end
      end else if (cfgWrEn && cfgAddr == ADDR_W'(A_INJ)) begin
        injPending <= 1'b1;
        pendVector <= cfgWrData[VEC_W-1:0];
        pendHasErr <= cfgWrData[ERR_BIT];
      end
      if (cfgWrEn && cfgAddr == ADDR_W'(A_INJERR)) pendErr <= cfgWrData;
    end
  end

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    exitStrobe |=> !exitStrobe);

  assert_left_guest_R9: assert property (@(posedge clk) disable iff (!rstN)
    exitStrobe |-> !inGuest);

  assert_reason_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    exitStrobe |-> (exitReason != RSN_NONE));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.enter && !anyExit) |=> $stable({exitReason, exitVector, exitErrCode, exitInfo}));

  assert_masked_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.crCommit && !gcrCfgWr) |=> (((guestCr0 ^ $past(guestCr0)) & $past(cr0Mask)) == '0));

  assert_inject_no_exit_R11: assert property (@(posedge clk) disable iff (!rstN)
    injStrobe |-> !exitStrobe);
endmodule

// File: rtl/guest_exit_filter.sv
module guest_exit_filter
  import gef_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 5,
  parameter int ADDR_W    = 4,
  parameter int PF_VECTOR = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              vmEnter,
  input  logic              excValid,
  input  logic [VEC_W-1:0]  excVector,
  input  logic [DATA_W-1:0] excErrCode,
  input  logic [DATA_W-1:0] excAddr,
  input  logic              crWrValid,
  input  logic [DATA_W-1:0] crWrData,
  input  logic              guestIf,
  output logic [DATA_W-1:0] crRdData,
  output logic [DATA_W-1:0] guestCr0,
  output logic              inGuest,
  output logic              exitStrobe,
  output logic [1:0]        exitReason,
  output logic [VEC_W-1:0]  exitVector,
  output logic [DATA_W-1:0] exitErrCode,
  output logic [DATA_W-1:0] exitInfo,
  output logic              excDeliver,
  output logic              injStrobe,
  output logic [VEC_W-1:0]  injVector,
  output logic              injHasErr,
  output logic [DATA_W-1:0] injErrCode
);
  localparam int BM_W = 1 << VEC_W;

  ctrlStrobes_t      strb;
  logic [BM_W-1:0]   excBitmap;
  logic [DATA_W-1:0] cr0Mask, cr0Shadow, pfMask, pfMatch;
  logic              winEn;

  gef_ctrl #(.DATA_W(DATA_W), .VEC_W(VEC_W), .PF_VECTOR(PF_VECTOR)) uCtrl (
    .clk(clk), .rstN(rstN), .vmEnter(vmEnter),
    .excValid(excValid), .excVector(excVector), .excErrCode(excErrCode),
    .crWrValid(crWrValid), .crWrData(crWrData), .guestIf(guestIf),
    .excBitmap(excBitmap), .cr0Mask(cr0Mask), .cr0Shadow(cr0Shadow),
    .pfMask(pfMask), .pfMatch(pfMatch), .winEn(winEn),
    .inGuest(inGuest), .strb(strb)
  );

  gef_dpath #(.DATA_W(DATA_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .strb(strb), .inGuest(inGuest),
    .excVector(excVector), .excErrCode(excErrCode), .excAddr(excAddr), .crWrData(crWrData),
    .excBitmap(excBitmap), .cr0Mask(cr0Mask), .cr0Shadow(cr0Shadow),
    .pfMask(pfMask), .pfMatch(pfMatch), .winEn(winEn),
    .crRdData(crRdData), .guestCr0(guestCr0),
    .exitStrobe(exitStrobe), .exitReason(exitReason), .exitVector(exitVector),
    .exitErrCode(exitErrCode), .exitInfo(exitInfo), .excDeliver(excDeliver),
    .injStrobe(injStrobe), .injVector(injVector), .injHasErr(injHasErr), .injErrCode(injErrCode)
  );
endmodule

// File: tb/tb_guest_exit_filter.sv
module tb_guest_exit_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        vmEnter = 1'b0;
  logic        excValid = 1'b0;
  logic [4:0]  excVector = '0;
  logic [31:0] excErrCode = '0;
  logic [31:0] excAddr = '0;
  logic        crWrValid = 1'b0;
  logic [31:0] crWrData = '0;
  logic        guestIf = 1'b0;
  logic [31:0] crRdData, guestCr0, exitErrCode, exitInfo, injErrCode;
  logic        inGuest, exitStrobe, excDeliver, injStrobe, injHasErr;
  logic [1:0]  exitReason;
  logic [4:0]  exitVector, injVector;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guest_exit_filter dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .vmEnter(vmEnter), .excValid(excValid), .excVector(excVector), .excErrCode(excErrCode),
    .excAddr(excAddr), .crWrValid(crWrValid), .crWrData(crWrData), .guestIf(guestIf),
    .crRdData(crRdData), .guestCr0(guestCr0), .inGuest(inGuest), .exitStrobe(exitStrobe),
    .exitReason(exitReason), .exitVector(exitVector), .exitErrCode(exitErrCode),
    .exitInfo(exitInfo), .excDeliver(excDeliver), .injStrobe(injStrobe),
    .injVector(injVector), .injHasErr(injHasErr), .injErrCode(injErrCode)
  );

  // exception filter table: bitmap, pfMask, pfMatch, vector, error code, expected exit
  localparam int NV = 8;
  localparam logic [31:0] T_BM [NV] = '{32'h80, 32'h0, 32'h80, 32'h8000_0000,
                                        32'h4000, 32'h4000, 32'h0, 32'h0};
  localparam logic [31:0] T_PM [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h2, 32'h2, 32'h2, 32'h1};
  localparam logic [31:0] T_PX [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h2, 32'h2, 32'h2, 32'h1};
  localparam logic [4:0]  T_VEC [NV] = '{5'd7, 5'd7, 5'd3, 5'd31, 5'd14, 5'd14, 5'd14, 5'd14};
  localparam logic [31:0] T_ERR [NV] = '{32'h0, 32'h0, 32'h0, 32'h5, 32'h2, 32'h0, 32'h0, 32'h3};
  localparam logic        T_EXIT [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic enter();
    @(negedge clk);
    vmEnter = 1'b1;
    @(negedge clk);
    vmEnter = 1'b0;
  endtask

  task automatic raiseExc(input logic [4:0] v, input logic [31:0] e, input logic [31:0] a);
    @(negedge clk);
    excValid = 1'b1; excVector = v; excErrCode = e; excAddr = a;
    @(negedge clk);
    excValid = 1'b0;
  endtask

  task automatic writeCr(input logic [31:0] d);
    @(negedge clk);
    crWrValid = 1'b1; crWrData = d;
    @(negedge clk);
    crWrValid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 exitStrobe", {31'd0, exitStrobe}, 32'd0);
    chk("R12 inGuest", {31'd0, inGuest}, 32'd0);
    chk("R12 exitReason", {30'd0, exitReason}, 32'd0);
    chk("R12 crRdData", crRdData, 32'd0);
    chk("R12 injStrobe", {31'd0, injStrobe}, 32'd0);

    // R9 events outside guest mode are ignored
    cfg(4'd0, 32'hFFFF_FFFF);
    raiseExc(5'd7, 32'h0, 32'h55);
    chk("R9 no exit outside guest", {31'd0, exitStrobe}, 32'd0);
    chk("R9 no delivery outside guest", {31'd0, excDeliver}, 32'd0);

    // R1 R2 table walk
    for (int i = 0; i < NV; i++) begin
      cfg(4'd0, T_BM[i]);
      cfg(4'd3, T_PM[i]);
      cfg(4'd4, T_PX[i]);
      enter();
      raiseExc(T_VEC[i], T_ERR[i], 32'h1000 + 32'(i));
      chk($sformatf("R1/R2 exit row %0d", i), {31'd0, exitStrobe}, {31'd0, T_EXIT[i]});
      chk($sformatf("R1/R2 deliver row %0d", i), {31'd0, excDeliver}, {31'd0, !T_EXIT[i]});
      if (T_EXIT[i]) begin
        chk("R7 reason exception", {30'd0, exitReason}, 32'd1);
        chk("R7 vector", {27'd0, exitVector}, {27'd0, T_VEC[i]});
        chk("R7 error code", exitErrCode, T_ERR[i]);
        chk("R7 fault address", exitInfo, 32'h1000 + 32'(i));
      end
    end

    // CR0 ownership
    cfg(4'd0, 32'h0);
    cfg(4'd6, 32'h11);
    cfg(4'd1, 32'h8);
    cfg(4'd2, 32'h8);
    chk("R5 blended read", crRdData, 32'h19);
    enter();
    writeCr(32'hF8);
    chk("R3 agreeing write no exit", {31'd0, exitStrobe}, 32'd0);
    chk("R4 unmasked bits updated", guestCr0, 32'hF0);
    chk("R5 read after write", crRdData, 32'hF8);
    writeCr(32'h1);
    chk("R3 differing write exits", {31'd0, exitStrobe}, 32'd1);
    chk("R7 reason cr0", {30'd0, exitReason}, 32'd2);
    chk("R7 cr0 info", exitInfo, 32'h1);
    chk("R3 write not applied", guestCr0, 32'hF0);
    chk("R9 guest mode left", {31'd0, inGuest}, 32'd0);
    @(negedge clk);
    chk("R9 strobe one cycle", {31'd0, exitStrobe}, 32'd0);
    chk("R10 reason held", {30'd0, exitReason}, 32'd2);
    writeCr(32'h0);
    chk("R9 cr write outside guest", guestCr0, 32'hF0);
    chk("R10 info held", exitInfo, 32'h1);
    enter();
    chk("R10 reason cleared", {30'd0, exitReason}, 32'd0);
    chk("R10 info cleared", exitInfo, 32'd0);

    // R6 interrupt window
    cfg(4'd5, 32'h1);
    repeat (3) begin
      @(negedge clk);
      chk("R6 closed window", {31'd0, exitStrobe}, 32'd0);
    end
    guestIf = 1'b1;
    @(negedge clk);
    guestIf = 1'b0;
    chk("R6 window exit", {31'd0, exitStrobe}, 32'd1);
    chk("R6 reason window", {30'd0, exitReason}, 32'd3);
    chk("R7 window info", exitInfo, 32'd0);

    // R8 priority
    enter();
    cfg(4'd0, 32'h20);
    @(negedge clk);
    excValid = 1'b1; excVector = 5'd5; excErrCode = 32'h9; excAddr = 32'h77;
    crWrValid = 1'b1; crWrData = 32'h0; guestIf = 1'b1;
    @(negedge clk);
    excValid = 1'b0; crWrValid = 1'b0; guestIf = 1'b0;
    chk("R8 exception first", {30'd0, exitReason}, 32'd1);
    chk("R8 vector", {27'd0, exitVector}, 32'd5);
    chk("R8 cr0 untouched", guestCr0, 32'hF0);
    enter();
    @(negedge clk);
    crWrValid = 1'b1; crWrData = 32'h0; guestIf = 1'b1;
    @(negedge clk);
    crWrValid = 1'b0; guestIf = 1'b0;
    chk("R8 cr0 before window", {30'd0, exitReason}, 32'd2);
    enter();
    @(negedge clk);
    excValid = 1'b1; excVector = 5'd5; crWrValid = 1'b1; crWrData = 32'hA8;
    @(negedge clk);
    excValid = 1'b0; crWrValid = 1'b0;
    chk("R8 exit blocks cr commit", guestCr0, 32'hF0);
    cfg(4'd5, 32'h0);

    // R11 injection
    cfg(4'd8, 32'hABCD);
    cfg(4'd7, 32'h10D);
    cfg(4'd0, 32'h2000);
    enter();
    chk("R11 inject strobe", {31'd0, injStrobe}, 32'd1);
    chk("R11 inject vector", {27'd0, injVector}, 32'd13);
    chk("R11 inject has error", {31'd0, injHasErr}, 32'd1);
    chk("R11 inject error code", injErrCode, 32'hABCD);
    chk("R11 inject no exit", {31'd0, exitStrobe}, 32'd0);
    @(negedge clk);
    chk("R11 inject one cycle", {31'd0, injStrobe}, 32'd0);
    enter();
    chk("R11 pending cleared", {31'd0, injStrobe}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule